// File: doc/BRIEF.md
# Texel Request Deduplication Unit

This block sits between a pair of texture engines and a set of texture memory banks. The two pixel processors feeding the texture engines shade neighbouring pixels. Their bilinear footprints therefore overlap, and the same texel address tends to show up more than once in a single set of eight tap requests. The same address also tends to reappear in the set that follows. The unit takes one set of up to eight tap addresses per accepted transfer. It discards every address that is already present earlier in the same set, and every address that the previous accepted set already requested. Only the surviving addresses reach memory, so a bank gets an enable only in the cycles in which it has real work.

Alongside the fetches, the unit reports, for every tap of the set, where its texel will come from. The source is either the tap inside the current set that owns the fetch, or a slot of the previous set whose texel is still held downstream. When two surviving addresses land in the same bank, they are issued in successive cycles. The input stays stalled until the last of them goes out. A flush input makes the unit forget the previous set. It is used when the texture base or mip level changes.

Top module: `texel_req_dedup`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ready` is 1, `mem_en` is all zero and `map_valid` is 0.
- R2: A set is accepted on a rising edge where `in_ready` is 1 and at least one bit of `in_vld` is 1. `map_valid` is 1 for exactly the one cycle that follows each accepting edge, and is 0 in every other cycle.
- R3: Within one set, a valid tap whose address is not held (see R4) takes as its source the lowest-indexed valid tap with the same address. Its `map_held` bit is 0 and its `map_idx` field is that tap's index. Only that lowest tap produces a fetch.
- R4: A valid tap whose address equals a valid address of the previous accepted set gets `map_held`=1. Its `map_idx` field is the lowest slot of that previous set holding the address, and the tap causes no fetch.
- R5: A tap address is 16 bits wide. The bank is address bits [2:0] and the row is bits [15:3]. A fetch raises `mem_en[bank]` and drives `mem_row` field `bank` (13 bits) with the row. It drives `mem_tag` field `bank` (3 bits) with the index of the tap that owns the fetch.
- R6: A bank with no fetch scheduled in a cycle has its `mem_en` bit at 0 in that cycle.
- R7: Fetches that share a bank are issued one per cycle in ascending tap order. The first round appears in the cycle after the accepting edge. `in_ready` is 0 until the cycle in which the last round is issued, and it is 1 in that cycle.
- R8: While `flush` is 1, the previous set is treated as empty for comparison. If no set is accepted on that edge, the held set is cleared. If a set is accepted on that edge, the held set becomes that new set.
- R9: An invalid tap (its `in_vld` bit is 0) produces no fetch and is never a source for another tap. It reports `map_tap_vld`=0, `map_held`=0 and `map_idx`=0. It does not count as a held address for the next set.
- R10: Taps presented while `in_ready` is 0 are ignored. They produce no map, no fetch and no change to the held set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Forget the held previous set |
| in_vld | input | 8 | Per-tap request valid |
| in_addr | input | 128 | Eight 16-bit tap addresses, tap i at bits [16i+15:16i] |
| in_ready | output | 1 | Unit can accept a set this cycle |
| mem_en | output | 8 | Per-bank fetch enable |
| mem_row | output | 104 | Per-bank 13-bit row, bank b at bits [13b+12:13b] |
| mem_tag | output | 24 | Per-bank 3-bit owning tap index |
| map_valid | output | 1 | Tap source map is valid this cycle |
| map_tap_vld | output | 8 | Tap was valid in the accepted set |
| map_held | output | 8 | Tap reuses a texel of the previous set |
| map_idx | output | 24 | Per-tap 3-bit source index (owning tap or held slot) |

## Verification
The source map of an accepted set is due exactly one cycle after the accepting edge. Fetch round r of that set is due r+1 cycles after it. `in_ready` is due back in the cycle of the final round, or the very next cycle when nothing was fetched. The bench stamps every expected map and every expected issue round with the cycle count at which it is due. Its monitor samples two nanoseconds after each rising edge and compares the stamp with the current count, so an early, late, missing or extra result is reported as well as a wrong one. Sets presented during a stall stay on the inputs, and this checks that nothing is taken before `in_ready` returns.

// File: rtl/trd_pkg.sv
package trd_pkg;
    localparam int TRD_TAPS   = 8;
    localparam int TRD_AW     = 16;
    localparam int TRD_BANK_W = 3;
    localparam int TRD_BANKS  = 1 << TRD_BANK_W;
    localparam int TRD_ROW_W  = TRD_AW - TRD_BANK_W;
    localparam int TRD_TAP_W  = $clog2(TRD_TAPS);

    typedef logic [TRD_AW-1:0]    addr_t;
    typedef logic [TRD_TAP_W-1:0] tidx_t;

    typedef struct packed {
        logic [TRD_TAPS-1:0]  pend;
        addr_t [TRD_TAPS-1:0] cur;
        addr_t [TRD_TAPS-1:0] held;
        logic [TRD_TAPS-1:0]  held_vld;
        logic                 map_valid;
        logic [TRD_TAPS-1:0]  map_vld;
        logic [TRD_TAPS-1:0]  map_held;
        tidx_t [TRD_TAPS-1:0] map_idx;
    } trd_state_t;
endpackage

// File: rtl/trd_match.sv
module trd_match
    import trd_pkg::*;
(
    input  logic [TRD_TAPS-1:0]  tap_vld,
    input  addr_t [TRD_TAPS-1:0] tap_addr,
    input  addr_t [TRD_TAPS-1:0] held_addr,
    input  logic [TRD_TAPS-1:0]  held_vld,
    output logic [TRD_TAPS-1:0]  hit_held,
    output logic [TRD_TAPS-1:0]  need_fetch,
    output tidx_t [TRD_TAPS-1:0] src_idx
);
    always_comb begin
        logic  hit;
        tidx_t hidx;
        tidx_t oidx;
        hit_held   = '0;
        need_fetch = '0;
        src_idx    = '0;
        for (int i = 0; i < TRD_TAPS; i++) begin
            hit  = 1'b0;
            hidx = '0;
            // descending scan leaves the lowest matching held slot
            for (int j = TRD_TAPS - 1; j >= 0; j--) begin
                if (held_vld[j] && (held_addr[j] == tap_addr[i])) begin
                    hit  = 1'b1;
                    hidx = tidx_t'(j);
                end
            end
            oidx = tidx_t'(i);
            for (int k = i - 1; k >= 0; k--) begin
                if (tap_vld[k] && (tap_addr[k] == tap_addr[i])) begin
                    oidx = tidx_t'(k);
                end
            end
            if (tap_vld[i]) begin
                if (hit) begin
                    hit_held[i] = 1'b1;
                    src_idx[i]  = hidx;
                end else begin
                    src_idx[i]    = oidx;
                    need_fetch[i] = (oidx == tidx_t'(i));
                end
            end
        end
    end
endmodule

// File: rtl/trd_bank_pick.sv
module trd_bank_pick
    import trd_pkg::*;
#(
    parameter int BANK = 0
) (
    input  logic [TRD_TAPS-1:0]  pend,
    input  addr_t [TRD_TAPS-1:0] addr,
    output logic                 en,
    output logic [TRD_ROW_W-1:0] row,
    output tidx_t                tag,
    output logic [TRD_TAPS-1:0]  grant
);
    localparam logic [TRD_BANK_W-1:0] BANK_ID = TRD_BANK_W'(BANK);

    always_comb begin
        en    = 1'b0;
        row   = '0;
        tag   = '0;
        grant = '0;
        // descending scan leaves the lowest pending tap for this bank
        for (int i = TRD_TAPS - 1; i >= 0; i--) begin
            if (pend[i] && (addr[i][TRD_BANK_W-1:0] == BANK_ID)) begin
                en       = 1'b1;
                row      = addr[i][TRD_AW-1:TRD_BANK_W];
                tag      = tidx_t'(i);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/texel_req_dedup.sv
module texel_req_dedup
    import trd_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic [TRD_TAPS-1:0]            in_vld,
    input  logic [TRD_TAPS*TRD_AW-1:0]     in_addr,
    output logic                           in_ready,
    output logic [TRD_BANKS-1:0]           mem_en,
    output logic [TRD_BANKS*TRD_ROW_W-1:0] mem_row,
    output logic [TRD_BANKS*TRD_TAP_W-1:0] mem_tag,
    output logic                           map_valid,
    output logic [TRD_TAPS-1:0]            map_tap_vld,
    output logic [TRD_TAPS-1:0]            map_held,
    output logic [TRD_TAPS*TRD_TAP_W-1:0]  map_idx
);
    trd_state_t st_q, st_d;

    addr_t [TRD_TAPS-1:0] in_arr;
    logic  [TRD_TAPS-1:0] cmp_held_vld;
    logic  [TRD_TAPS-1:0] hit_held;
    logic  [TRD_TAPS-1:0] need_fetch;
    tidx_t [TRD_TAPS-1:0] src_idx;

    logic  [TRD_BANKS-1:0][TRD_TAPS-1:0]  grant_b;
    logic  [TRD_BANKS-1:0][TRD_ROW_W-1:0] row_b;
    tidx_t [TRD_BANKS-1:0]                tag_b;
    logic  [TRD_TAPS-1:0]                 grant_all;
    logic  [TRD_TAPS-1:0]                 remain;
    logic                                 accept;

    assign in_arr       = in_addr;
    assign cmp_held_vld = flush ? '0 : st_q.held_vld;

    trd_match u_match (
        .tap_vld    (in_vld),
        .tap_addr   (in_arr),
        .held_addr  (st_q.held),
        .held_vld   (cmp_held_vld),
        .hit_held   (hit_held),
        .need_fetch (need_fetch),
        .src_idx    (src_idx)
    );

    for (genvar b = 0; b < TRD_BANKS; b++) begin : g_bank
        trd_bank_pick #(.BANK(b)) u_pick (
            .pend  (st_q.pend),
            .addr  (st_q.cur),
            .en    (mem_en[b]),
            .row   (row_b[b]),
            .tag   (tag_b[b]),
            .grant (grant_b[b])
        );
    end

    always_comb begin
        grant_all = '0;
        for (int b = 0; b < TRD_BANKS; b++) begin
            grant_all = grant_all | grant_b[b];
        end
    end

    assign remain   = st_q.pend & ~grant_all;
    assign in_ready = ~|remain;
    assign accept   = in_ready & (|in_vld);

    always_comb begin
        st_d           = st_q;
        st_d.map_valid = 1'b0;
        st_d.pend      = remain;
        if (accept) begin
            st_d.pend      = need_fetch;
            st_d.cur       = in_arr;
            st_d.held      = in_arr;
            st_d.held_vld  = in_vld;
            st_d.map_valid = 1'b1;
            st_d.map_vld   = in_vld;
            st_d.map_held  = hit_held;
            st_d.map_idx   = src_idx;
        end else if (flush) begin
            st_d.held_vld = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_row     = row_b;
    assign mem_tag     = tag_b;
    assign map_valid   = st_q.map_valid;
    assign map_tap_vld = st_q.map_vld;
    assign map_held    = st_q.map_held;
    assign map_idx     = st_q.map_idx;
endmodule

// File: rtl/trd_checker.sv
module trd_checker
    import trd_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [TRD_TAPS-1:0]  in_vld,
    input logic                 in_ready,
    input logic [TRD_BANKS-1:0] mem_en,
    input logic                 map_valid,
    input logic [TRD_TAPS-1:0]  map_tap_vld,
    input logic [TRD_TAPS-1:0]  map_held
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (in_ready && (mem_en == '0) && !map_valid));

    p_accept_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && (|in_vld)) |=> map_valid);

    p_stall_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && (|in_vld)) |=> !map_valid);

    p_busy_issues_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (|mem_en));

    p_map_taps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        map_valid |-> (map_tap_vld == $past(in_vld)));

    p_held_valid_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        map_valid |-> ((map_held & ~map_tap_vld) == '0));
endmodule

bind texel_req_dedup trd_checker u_trd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_vld      (in_vld),
    .in_ready    (in_ready),
    .mem_en      (mem_en),
    .map_valid   (map_valid),
    .map_tap_vld (map_tap_vld),
    .map_held    (map_held)
);

// File: tb/texel_req_dedup_test.sv
module texel_req_dedup_test;
    import trd_pkg::*;

    localparam int NT = TRD_TAPS;
    localparam int AW = TRD_AW;
    localparam int NB = TRD_BANKS;
    localparam int RW = TRD_ROW_W;
    localparam int TW = TRD_TAP_W;
    localparam int BW = TRD_BANK_W;

    typedef logic [NT-1:0][AW-1:0] aset_t;

    typedef struct {
        int            due;
        logic [NT-1:0] tv;
        logic [NT-1:0] hl;
        logic [NT*TW-1:0] ix;
        string         lbl;
    } map_item_t;

    typedef struct {
        int               due;
        logic [NB-1:0]    en;
        logic [NB*RW-1:0] row;
        logic [NB*TW-1:0] tag;
        string            lbl;
    } iss_item_t;

    logic clk = 1'b0;
    logic rst_n, flush;
    logic [NT-1:0] in_vld;
    logic [NT*AW-1:0] in_addr;
    logic in_ready;
    logic [NB-1:0] mem_en;
    logic [NB*RW-1:0] mem_row;
    logic [NB*TW-1:0] mem_tag;
    logic map_valid;
    logic [NT-1:0] map_tap_vld, map_held;
    logic [NT*TW-1:0] map_idx;

    always #4 clk = ~clk;

    texel_req_dedup uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_vld(in_vld),
        .in_addr(in_addr), .in_ready(in_ready), .mem_en(mem_en),
        .mem_row(mem_row), .mem_tag(mem_tag), .map_valid(map_valid),
        .map_tap_vld(map_tap_vld), .map_held(map_held), .map_idx(map_idx)
    );

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit mon_on = 0;
    int exp_ready_from = 0;
    map_item_t mq[$];
    iss_item_t iq[$];
    aset_t m_ha;
    logic [NT-1:0] m_hv = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Reference model built from the requirements; pushes stamped expectations.
    task automatic push_expected(input logic [NT-1:0] v, input aset_t a,
                                 input bit fl, input string lbl);
        logic [NT-1:0] hv, need;
        map_item_t mi;
        int depth[NB];
        int rounds;
        hv = fl ? '0 : m_hv;
        need = '0;
        mi.due = cyc + 1; mi.tv = v; mi.hl = '0; mi.ix = '0; mi.lbl = lbl;
        for (int i = 0; i < NT; i++) begin
            if (v[i]) begin
                int hit, own;
                hit = -1;
                for (int j = 0; j < NT; j++)
                    if (hit < 0 && hv[j] && m_ha[j] == a[i]) hit = j;
                if (hit >= 0) begin
                    mi.hl[i] = 1'b1;           // R4
                    mi.ix[i*TW +: TW] = TW'(hit);
                end else begin
                    own = i;
                    for (int k = 0; k < i; k++)
                        if (own == i && v[k] && a[k] == a[i]) own = k;
                    mi.ix[i*TW +: TW] = TW'(own); // R3
                    if (own == i) need[i] = 1'b1;
                end
            end
        end
        mq.push_back(mi);
        for (int b = 0; b < NB; b++) depth[b] = 0;
        for (int i = 0; i < NT; i++)
            if (need[i]) depth[int'(a[i][BW-1:0])]++;
        rounds = 0;
        for (int b = 0; b < NB; b++) if (depth[b] > rounds) rounds = depth[b];
        for (int r = 0; r < rounds; r++) begin
            iss_item_t it;
            it.due = cyc + 1 + r; it.en = '0; it.row = '0; it.tag = '0; it.lbl = lbl;
            for (int b = 0; b < NB; b++) begin
                int cnt;
                cnt = 0;
                for (int i = 0; i < NT; i++) begin
                    if (need[i] && int'(a[i][BW-1:0]) == b) begin
                        if (cnt == r) begin
                            it.en[b] = 1'b1;
                            it.row[b*RW +: RW] = a[i][AW-1:BW];
                            it.tag[b*TW +: TW] = TW'(i);
                        end
                        cnt++;
                    end
                end
            end
            iq.push_back(it);
        end
        exp_ready_from = cyc + ((rounds > 1) ? rounds : 1);
        m_ha = a;
        m_hv = v;
    endtask

    task automatic send(input logic [NT-1:0] v, input aset_t a, input bit fl, input string lbl);
        @(negedge clk);
        in_vld = v; in_addr = a; flush = fl;
        while (!in_ready) @(negedge clk);   // R10: held on the inputs while stalled
        push_expected(v, a, fl, lbl);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_vld = '0; flush = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic flush_only();
        @(negedge clk);
        in_vld = '0; flush = 1'b1;
        m_hv = '0;                          // R8
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && mon_on) begin
                if (map_valid) begin
                    if (mq.size() == 0) begin
                        chk(0, "R2", "unexpected map_valid", 1, 0);
                    end else begin
                        map_item_t m;
                        m = mq.pop_front();
                        chk(m.due == cyc, "R2", {m.lbl, " map cycle"}, 128'(cyc), 128'(m.due));
                        chk(map_tap_vld == m.tv, "R9", {m.lbl, " map_tap_vld"}, 128'(map_tap_vld), 128'(m.tv));
                        chk(map_held == m.hl, "R4", {m.lbl, " map_held"}, 128'(map_held), 128'(m.hl));
                        chk(map_idx == m.ix, "R3", {m.lbl, " map_idx"}, 128'(map_idx), 128'(m.ix));
                    end
                end else if (mq.size() != 0 && mq[0].due <= cyc) begin
                    chk(0, "R2", "missing map_valid", 0, 1);
                    void'(mq.pop_front());
                end
                if (mem_en != '0) begin
                    if (iq.size() == 0) begin
                        chk(0, "R6", "unexpected mem_en", 128'(mem_en), 0);
                    end else begin
                        iss_item_t it;
                        it = iq.pop_front();
                        chk(it.due == cyc, "R7", {it.lbl, " issue cycle"}, 128'(cyc), 128'(it.due));
                        chk(mem_en == it.en, "R6", {it.lbl, " mem_en"}, 128'(mem_en), 128'(it.en));
                        chk(mem_row == it.row, "R5", {it.lbl, " mem_row"}, 128'(mem_row), 128'(it.row));
                        chk(mem_tag == it.tag, "R5", {it.lbl, " mem_tag"}, 128'(mem_tag), 128'(it.tag));
                    end
                end else if (iq.size() != 0 && iq[0].due <= cyc) begin
                    chk(0, "R7", "missing issue round", 0, 128'(iq[0].en));
                    void'(iq.pop_front());
                end
                chk(in_ready == (cyc >= exp_ready_from), "R7", "in_ready",
                    128'(in_ready), 128'(cyc >= exp_ready_from));
            end
        end
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        aset_t a, t5;
        rst_n = 1'b0; flush = 1'b0; in_vld = '0; in_addr = '0;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", 128'(in_ready), 1);
        chk(mem_en == '0, "R1", "mem_en in reset", 128'(mem_en), 0);
        chk(map_valid == 1'b0, "R1", "map_valid in reset", 128'(map_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && mem_en == '0 && !map_valid, "R1", "after reset",
            128'({in_ready, mem_en, map_valid}), 128'({1'b1, 8'h00, 1'b0}));
        exp_ready_from = cyc;
        mon_on = 1;

        // R5 R6: eight distinct banks, one round
        for (int i = 0; i < NT; i++) a[i] = AW'(16'h0100 + i);
        send('1, a, 0, "distinct");
        // R4: identical set is fully held
        send('1, a, 0, "repeat");
        idle(2);
        // R3 R7: overlapping footprints of adjacent pixels, bank conflicts
        a[0] = 16'h0200; a[1] = 16'h0201; a[2] = 16'h0240; a[3] = 16'h0241;
        a[4] = 16'h0201; a[5] = 16'h0202; a[6] = 16'h0241; a[7] = 16'h0242;
        send('1, a, 0, "overlap");
        // R7: all taps hit bank 0 with distinct rows -> eight rounds
        for (int i = 0; i < NT; i++) a[i] = AW'(16'h1000 + i * 8);
        send('1, a, 0, "same_bank");
        // R9 R10: partial set presented during the stall
        t5 = '0;
        t5[0] = 16'h0300; t5[1] = 16'h0300; t5[2] = 16'h0555; t5[3] = 16'h0303;
        t5[4] = 16'h0304; t5[5] = 16'h0303; t5[6] = 16'h0306; t5[7] = 16'h0307;
        send(8'b1011_1010, t5, 0, "partial");
        // R9: invalid-tap address must not be treated as held
        for (int i = 0; i < NT; i++) a[i] = AW'(16'h0300 + i);
        a[2] = 16'h0555;
        send('1, a, 0, "after_partial");
        idle(1);
        // R8: flush alone then identical set -> nothing held
        flush_only();
        send('1, a, 0, "after_flush");
        // R8: flush coinciding with accept
        send('1, a, 1, "flush_accept");
        send('1, a, 0, "held_after_flush_accept");
        idle(3);

        // Mixed traffic with a small address space
        for (int n = 0; n < 400; n++) begin
            logic [NT-1:0] v;
            for (int i = 0; i < NT; i++)
                a[i] = AW'(16'h0800 + (($urandom % 4) << BW) + ($urandom % NB));
            v = NT'($urandom);
            if (v == '0) v = 8'h01;
            send(v, a, ($urandom % 16) == 0, "mixed");
            if (($urandom % 8) == 0) idle($urandom % 3);
        end
        idle(20);
        chk(mq.size() == 0, "R2", "maps left unseen", 128'(mq.size()), 0);
        chk(iq.size() == 0, "R7", "issues left unseen", 128'(iq.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule